// File: doc/BRIEF.md
# SPI Command Frame Encoder

This block turns one command request into the byte sequence that opens a transaction on an SPI link to a peripheral. The request carries an opcode, an address, write data, a transfer size and a clockless flag. The encoder lays these out in the byte order that the opcode defines. It hands the bytes one at a time to an SPI shifter over a valid/ready stream. When CRC protection is enabled for the request, it appends one checksum byte.

After the last frame byte has been accepted, the encoder waits for the two-byte command response on a separate byte input. The first response byte must echo the opcode and the second must be zero. The encoder then pulses `done`, and pulses `err` at the same time if the response is wrong. A request with an opcode outside the supported set is refused on the spot with an error pulse. The data phase that may follow a command is handled elsewhere.

Top module: `spi_cmd_framer`

## Requirements
- R1: Supported opcodes are 0xC1 to 0xCA and 0xCF. An accepted request presents its opcode as the first stream byte in the cycle after acceptance.
- R2: Single read (0xCA) sends address bytes [23:16], [15:8], [7:0] after the opcode. Single write (0xC9) then adds data bytes [31:24], [23:16], [15:8], [7:0].
- R3: Internal read (0xC4) sends {addr[15] OR clockless, addr[14:8]}, then addr[7:0], then 0x00. Internal write (0xC3) sends the same two address bytes followed by the four data bytes, most significant first.
- R4: DMA write/read (0xC1/0xC2) send three address bytes and then size[15:8], size[7:0]. Extended DMA write/read (0xC7/0xC8) send three address bytes and then size[23:16], size[15:8], size[7:0]. All fields go most significant byte first.
- R5: Reset (0xCF) sends three 0xFF bytes after the opcode. Terminate (0xC5) and repeat (0xC6) send three 0x00 bytes.
- R6: With `crc7_en` set at request time, one extra byte follows the frame. Its bits [7:1] are the CRC over all previous frame bytes, using polynomial x^7+x^3+1, bits processed MSB first, and the register preset to all ones. Bit 0 is always 1.
- R7: With `crc7_en` clear, no byte follows the last field byte, and `tx_valid` drops after it.
- R8: After the frame, the first `rsp_valid` byte is compared with the opcode and the second with 0x00. `done` pulses for one cycle in the cycle after the second byte is taken. `err` pulses with it if either comparison fails.
- R9: For opcodes 0xC3, 0xC4, 0xC9 and 0xCA sent with the clockless flag set, response mismatches raise no error. For every other opcode the clockless flag does not suppress the error.
- R10: While `tx_valid` is high and `tx_ready` low, `tx_byte` holds its value. `req_ready` stays low from acceptance until the cycle after `done`.
- R11: After reset, `req_ready` is 1 and `tx_valid`, `done` and `err` are 0.
- R12: A request with an unsupported opcode makes `err` high for exactly one cycle, in the cycle after acceptance. No byte is emitted and `done` stays low. `req_ready` returns one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Encoder can take a request |
| req_op | input | 8 | Opcode |
| req_addr | input | 24 | Address |
| req_data | input | 32 | Write data for single and internal writes |
| req_size | input | 24 | Transfer size for DMA commands |
| req_cl | input | 1 | Clockless access flag |
| crc7_en | input | 1 | Append the CRC byte to this frame |
| tx_valid | output | 1 | Stream byte present |
| tx_ready | input | 1 | Shifter takes the stream byte |
| tx_byte | output | 8 | Stream byte |
| rsp_valid | input | 1 | Response byte present |
| rsp_byte | input | 8 | Response byte |
| done | output | 1 | Command finished (one-cycle pulse) |
| err | output | 1 | Rejection or response error (one-cycle pulse) |

## Verification
The bench builds the encoder with its default parameters: an eight-byte frame store, the x^7+x^3+1 polynomial and an all-ones preset. With these values, all 256 opcode values can be swept. Each supported opcode is run under three address/data/size patterns, both clockless settings, both CRC settings and three response outcomes (correct, wrong echo, nonzero status). Alternating backpressure is applied on one pattern. This covers every frame layout, every checksum position and every case where the response error is suppressed or kept.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int SIZE_W = 24;

  localparam logic [7:0] OP_DMA_WR  = 8'hC1;
  localparam logic [7:0] OP_DMA_RD  = 8'hC2;
  localparam logic [7:0] OP_INT_WR  = 8'hC3;
  localparam logic [7:0] OP_INT_RD  = 8'hC4;
  localparam logic [7:0] OP_TERM    = 8'hC5;
  localparam logic [7:0] OP_REPEAT  = 8'hC6;
  localparam logic [7:0] OP_XDMA_WR = 8'hC7;
  localparam logic [7:0] OP_XDMA_RD = 8'hC8;
  localparam logic [7:0] OP_SGL_WR  = 8'hC9;
  localparam logic [7:0] OP_SGL_RD  = 8'hCA;
  localparam logic [7:0] OP_RESET   = 8'hCF;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_CRC, ST_RSP} fr_state_t;

  function automatic logic op_known(input logic [7:0] op);
    case (op)
      OP_DMA_WR, OP_DMA_RD, OP_INT_WR, OP_INT_RD, OP_TERM, OP_REPEAT,
      OP_XDMA_WR, OP_XDMA_RD, OP_SGL_WR, OP_SGL_RD, OP_RESET: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Opcodes whose response check is waived for clockless accesses
  function automatic logic op_lenient(input logic [7:0] op);
    return (op == OP_INT_WR) || (op == OP_INT_RD) ||
           (op == OP_SGL_WR) || (op == OP_SGL_RD);
  endfunction
endpackage

// File: rtl/spi_cmd_crc7.sv
module spi_cmd_crc7 #(
  parameter logic [6:0] POLY = 7'h09
) (
  input  logic [6:0] crc_in,
  input  logic [7:0] din,
  output logic [6:0] crc_out
);
  logic [6:0] stage [9];
  assign stage[0] = crc_in;

  for (genvar g = 0; g < 8; g++) begin : g_bit
    logic fb;
    assign fb = stage[g][6] ^ din[7-g];
    assign stage[g+1] = {stage[g][5:0], 1'b0} ^ ({7{fb}} & POLY);
  end

  assign crc_out = stage[8];
endmodule

// File: rtl/spi_cmd_layout.sv
module spi_cmd_layout
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_BYTES = 8,
  parameter int LEN_W       = 4
) (
  input  logic [7:0]                    op,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             data,
  input  logic [SIZE_W-1:0]             size,
  input  logic                          clockless,
  output logic [FRAME_BYTES*BYTE_W-1:0] frame,
  output logic [LEN_W-1:0]              len
);
  logic [BYTE_W-1:0] b [FRAME_BYTES];

  always_comb begin
    for (int i = 0; i < FRAME_BYTES; i++) b[i] = '0;
    b[0] = op;
    len  = '0;
    case (op)
      OP_SGL_RD, OP_SGL_WR: begin
        b[1] = addr[23:16]; b[2] = addr[15:8]; b[3] = addr[7:0];
        if (op == OP_SGL_WR) begin
          b[4] = data[31:24]; b[5] = data[23:16];
          b[6] = data[15:8];  b[7] = data[7:0];
          len  = LEN_W'(8);
        end else begin
          len  = LEN_W'(4);
        end
      end
      OP_INT_RD, OP_INT_WR: begin
        b[1] = {addr[15] | clockless, addr[14:8]};
        b[2] = addr[7:0];
        if (op == OP_INT_WR) begin
          b[3] = data[31:24]; b[4] = data[23:16];
          b[5] = data[15:8];  b[6] = data[7:0];
          len  = LEN_W'(7);
        end else begin
          len  = LEN_W'(4);
        end
      end
      OP_DMA_WR, OP_DMA_RD: begin
        b[1] = addr[23:16]; b[2] = addr[15:8]; b[3] = addr[7:0];
        b[4] = size[15:8];  b[5] = size[7:0];
        len  = LEN_W'(6);
      end
      OP_XDMA_WR, OP_XDMA_RD: begin
        b[1] = addr[23:16]; b[2] = addr[15:8]; b[3] = addr[7:0];
        b[4] = size[23:16]; b[5] = size[15:8]; b[6] = size[7:0];
        len  = LEN_W'(7);
      end
      OP_RESET: begin
        b[1] = 8'hFF; b[2] = 8'hFF; b[3] = 8'hFF;
        len  = LEN_W'(4);
      end
      OP_TERM, OP_REPEAT: len = LEN_W'(4);
      default: len = '0;
    endcase
  end

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_pack
    assign frame[g*BYTE_W +: BYTE_W] = b[g];
  end
endmodule

// File: rtl/spi_cmd_rsp_chk.sv
module spi_cmd_rsp_chk (
  input  logic       clk,
  input  logic       rst,
  input  logic       arm,
  input  logic [7:0] exp_op,
  input  logic       lenient,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_byte,
  output logic       done,
  output logic       err
);
  logic [1:0] ph_q;
  logic       bad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= 2'd0;
      bad_q <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (ph_q)
        2'd0: if (arm) ph_q <= 2'd1;
        2'd1: if (rsp_valid) begin
          bad_q <= (rsp_byte != exp_op);
          ph_q  <= 2'd2;
        end
        2'd2: if (rsp_valid) begin
          done <= 1'b1;
          err  <= (bad_q || (rsp_byte != 8'h00)) && !lenient;
          ph_q <= 2'd0;
        end
        default: ph_q <= 2'd0;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
  import spi_cmd_pkg::*;
#(
  parameter int         FRAME_BYTES = 8,
  parameter logic [6:0] CRC_POLY    = 7'h09,
  parameter logic [6:0] CRC_SEED    = 7'h7F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_cl,
  input  logic              crc7_en,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_byte,
  output logic              done,
  output logic              err
);
  localparam int LEN_W = $clog2(FRAME_BYTES + 1);
  localparam int FW    = FRAME_BYTES * BYTE_W;

  fr_state_t         st_q;
  logic [FW-1:0]     frame_w, frame_q;
  logic [LEN_W-1:0]  len_w, len_q, idx_q;
  logic [7:0]        op_q, tx_byte_q;
  logic              cl_q, crc_on_q, tx_valid_q, rej_q;
  logic [6:0]        crc_q, crc_nx;
  logic              hs, last_field, arm_w, rsp_done, rsp_err;

  spi_cmd_layout #(.FRAME_BYTES(FRAME_BYTES), .LEN_W(LEN_W)) u_layout (
    .op(req_op), .addr(req_addr), .data(req_data), .size(req_size),
    .clockless(req_cl), .frame(frame_w), .len(len_w)
  );

  spi_cmd_crc7 #(.POLY(CRC_POLY)) u_crc (
    .crc_in(crc_q), .din(tx_byte_q), .crc_out(crc_nx)
  );

  assign hs         = tx_valid_q && tx_ready;
  assign last_field = (st_q == ST_SEND) && (idx_q == len_q);
  assign arm_w      = hs && ((last_field && !crc_on_q) || (st_q == ST_CRC));

  spi_cmd_rsp_chk u_rsp (
    .clk(clk), .rst(rst), .arm(arm_w), .exp_op(op_q),
    .lenient(cl_q && op_lenient(op_q)),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .done(rsp_done), .err(rsp_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      frame_q    <= '0;
      len_q      <= '0;
      idx_q      <= '0;
      op_q       <= '0;
      cl_q       <= 1'b0;
      crc_on_q   <= 1'b0;
      crc_q      <= CRC_SEED;
      tx_byte_q  <= '0;
      tx_valid_q <= 1'b0;
      rej_q      <= 1'b0;
    end else begin
      rej_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid && req_ready) begin
          if (!op_known(req_op)) begin
            rej_q <= 1'b1;
          end else begin
            frame_q    <= frame_w;
            len_q      <= len_w;
            op_q       <= req_op;
            cl_q       <= req_cl;
            crc_on_q   <= crc7_en;
            crc_q      <= CRC_SEED;
            idx_q      <= LEN_W'(1);
            tx_byte_q  <= req_op;
            tx_valid_q <= 1'b1;
            st_q       <= ST_SEND;
          end
        end
        ST_SEND: if (hs) begin
          crc_q <= crc_nx;
          if (idx_q == len_q) begin
            if (crc_on_q) begin
              tx_byte_q <= {crc_nx, 1'b1};
              st_q      <= ST_CRC;
            end else begin
              tx_valid_q <= 1'b0;
              st_q       <= ST_RSP;
            end
          end else begin
            tx_byte_q <= frame_q[{idx_q, 3'b000} +: BYTE_W];
            idx_q     <= idx_q + LEN_W'(1);
          end
        end
        ST_CRC: if (hs) begin
          tx_valid_q <= 1'b0;
          st_q       <= ST_RSP;
        end
        ST_RSP: if (rsp_done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE) && !rej_q && !rsp_done;
  assign tx_valid  = tx_valid_q;
  assign tx_byte   = tx_byte_q;
  assign done      = rsp_done;
  assign err       = rej_q | rsp_err;
endmodule

// File: rtl/spi_cmd_framer_chk.sv
module spi_cmd_framer_chk
  import spi_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] req_op,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic       rsp_valid,
  input logic       done,
  input logic       err
);
  AST_FIRST_IS_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && op_known(req_op)) |=> (tx_valid && tx_byte == $past(req_op))); // R1

  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !op_known(req_op)) |=> (err && !tx_valid && !done)); // R12

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    err |=> !err); // R12

  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rsp_valid)); // R8

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R10

  AST_BUSY_WHILE_TX: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !req_ready); // R10
endmodule

bind spi_cmd_framer spi_cmd_framer_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_byte(tx_byte), .rsp_valid(rsp_valid), .done(done), .err(err)
);

// File: tb/spi_cmd_framer_bench.sv
`timescale 1ns/1ps
module spi_cmd_framer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_cl = 1'b0, crc7_en = 1'b0;
  logic [7:0]  req_op = '0;
  logic [23:0] req_addr = '0, req_size = '0;
  logic [31:0] req_data = '0;
  logic        tx_ready = 1'b1, rsp_valid = 1'b0;
  logic [7:0]  rsp_byte = '0;
  logic        req_ready, tx_valid, done, err;
  logic [7:0]  tx_byte;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  spi_cmd_framer u_spi_cmd_framer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .req_size(req_size), .req_cl(req_cl), .crc7_en(crc7_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit b_known(input logic [7:0] op);
    return (op >= 8'hC1 && op <= 8'hCA) || op == 8'hCF;
  endfunction

  function automatic bit b_lenient(input logic [7:0] op);
    return op == 8'hC3 || op == 8'hC4 || op == 8'hC9 || op == 8'hCA;
  endfunction

  function automatic string b_tag(input logic [7:0] op);
    if (op == 8'hC9 || op == 8'hCA) return "R2";
    if (op == 8'hC3 || op == 8'hC4) return "R3";
    if (op == 8'hC1 || op == 8'hC2 || op == 8'hC7 || op == 8'hC8) return "R4";
    return "R5";
  endfunction

  task automatic b_frame(input logic [7:0] op, input logic [23:0] a,
                         input logic [31:0] d, input logic [23:0] s,
                         input bit cl, input bit crc,
                         output logic [7:0] f [10], output int n);
    logic [7:0] c;
    for (int i = 0; i < 10; i++) f[i] = 8'h00;
    n = 0;
    f[n++] = op;
    if (op == 8'hC3 || op == 8'hC4) begin
      f[n++] = 8'((a >> 8) & 24'hFF) | (cl ? 8'h80 : 8'h00);
      f[n++] = 8'(a & 24'hFF);
      if (op == 8'hC4) f[n++] = 8'h00;
      else for (int k = 3; k >= 0; k--) f[n++] = 8'(d >> (8 * k));
    end else begin
      for (int k = 2; k >= 0; k--)
        f[n++] = (op == 8'hCF) ? 8'hFF : (op == 8'hC5 || op == 8'hC6) ? 8'h00 : 8'(a >> (8 * k));
      if (op == 8'hC9) for (int k = 3; k >= 0; k--) f[n++] = 8'(d >> (8 * k));
      if (op == 8'hC1 || op == 8'hC2) for (int k = 1; k >= 0; k--) f[n++] = 8'(s >> (8 * k));
      if (op == 8'hC7 || op == 8'hC8) for (int k = 2; k >= 0; k--) f[n++] = 8'(s >> (8 * k));
    end
    if (crc) begin
      c = 8'hFE;
      for (int i = 0; i < n; i++) begin
        c = c ^ f[i];
        for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h12) : (c << 1);
      end
      f[n++] = c | 8'h01;
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [23:0] a,
                     input logic [31:0] d, input logic [23:0] s,
                     input bit cl, input bit crc, input int rmode, input bit bp);
    logic [7:0] f [10];
    int n, got, guard;
    logic [7:0] held;
    bit holding, exp_err;
    string tg;
    b_frame(op, a, d, s, cl, crc, f, n);
    chk(req_ready === 1'b1, "R10", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    req_size = s; req_cl = cl; crc7_en = crc;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (!b_known(op)) begin
      chk(err === 1'b1, "R12", "reject err pulse", int'(err), 1);
      chk(tx_valid === 1'b0 && done === 1'b0, "R12", "no byte on reject", int'(tx_valid), 0);
      chk(req_ready === 1'b0, "R12", "ready low in err cycle", int'(req_ready), 0);
      @(negedge clk);
      chk(err === 1'b0 && req_ready === 1'b1 && tx_valid === 1'b0, "R12",
          "err ends, ready back", int'({err, req_ready, tx_valid}), 3'b010);
      return;
    end
    chk(req_ready === 1'b0, "R10", "busy after accept", int'(req_ready), 0);
    got = 0; guard = 0; holding = 0;
    while (got < n && guard < 100) begin
      tx_ready = bp ? guard[0] : 1'b1;
      if (holding)
        chk(tx_valid === 1'b1 && tx_byte === held, "R10", "byte held under stall",
            int'(tx_byte), int'(held));
      if (tx_valid === 1'b1 && tx_ready) begin
        tg = (crc && got == n - 1) ? "R6" : (got == 0) ? "R1" : b_tag(op);
        chk(tx_byte === f[got], tg, $sformatf("op %0h byte %0d", op, got),
            int'(tx_byte), int'(f[got]));
        got++;
        holding = 0;
      end else if (tx_valid === 1'b1) begin
        holding = 1; held = tx_byte;
      end
      @(negedge clk);
      guard++;
    end
    tx_ready = 1'b1;
    chk(got == n, crc ? "R6" : "R7", "frame byte count", got, n);
    chk(tx_valid === 1'b0, crc ? "R6" : "R7", "no byte after frame", int'(tx_valid), 0);
    rsp_valid = 1'b1;
    rsp_byte  = (rmode == 1) ? (op ^ 8'h01) : op;
    @(negedge clk);
    rsp_byte  = (rmode == 2) ? 8'h04 : 8'h00;
    @(negedge clk);
    rsp_valid = 1'b0;
    exp_err = (rmode != 0) && !(cl && b_lenient(op));
    chk(done === 1'b1, "R8", "done pulse", int'(done), 1);
    chk(err === exp_err, (cl && b_lenient(op)) ? "R9" : "R8",
        $sformatf("op %0h resp err mode %0d", op, rmode), int'(err), int'(exp_err));
    @(negedge clk);
    chk(done === 1'b0 && err === 1'b0 && req_ready === 1'b1, "R8", "pulse ends",
        int'({done, err, req_ready}), 3'b001);
  endtask

  initial begin
    logic [23:0] pa [3];
    logic [31:0] pd [3];
    logic [23:0] ps [3];
    pa[0] = 24'h000000; pd[0] = 32'h00000000; ps[0] = 24'h000000;
    pa[1] = 24'h5A7E81; pd[1] = 32'hDEADBEEF; ps[1] = 24'h012345;
    pa[2] = 24'hFFFFFF; pd[2] = 32'hFFFFFFFF; ps[2] = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R11", "reset req_ready", int'(req_ready), 1);
    chk(tx_valid === 1'b0, "R11", "reset tx_valid", int'(tx_valid), 0);
    chk(done === 1'b0 && err === 1'b0, "R11", "reset pulses", int'({done, err}), 0);
    rst = 1'b0;
    @(negedge clk);
    for (int op = 0; op < 256; op++) begin
      if (!b_known(8'(op))) begin
        run(8'(op), 24'h123456, 32'h0, 24'h0, 1'b0, 1'b0, 0, 1'b0);
      end else begin
        for (int v = 0; v < 3; v++)
          for (int cl = 0; cl < 2; cl++)
            for (int crc = 0; crc < 2; crc++)
              for (int rm = 0; rm < 3; rm++)
                run(8'(op), pa[v], pd[v], ps[v], cl[0], crc[0], rm, v == 1);
      end
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule